// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds a small bank of one-bit ownership flags that two independent agents, a left port and a right port, use to coordinate software access to shared regions. A port claims a flag by writing a 0 to it and gives it back by writing a 1. A read returns the flag's status as that port sees it: 0 means "this port owns it", 1 means "free or held by the other side". Each port selects the semaphore space by asserting its flag select while keeping its memory enable low. Any other combination leaves the flags alone.

The model is fully synchronous: both ports are sampled on the same rising clock edge. A claim that meets a flag the other port already holds is refused, but the bank remembers it. When the owner later releases the flag, ownership moves to the waiting port on that same edge. When both ports claim a free flag on the same edge, the left port wins and the right claim is kept as pending. A port that writes 1 to a flag it does not own cancels its own pending claim.

Top module: `sem_latch_bank`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a clock edge) frees every flag, clears every pending claim, and sets both data outputs to all ones.
- R2: A port touches the bank only when its flag select is 1 and its memory enable is 0. With any other combination, its write changes no flag and its data output keeps its value.
- R3: A claim (write with `din[0]`=0) on a free flag makes the claimant the owner. The owner then reads 0 and the other port reads 1.
- R4: Writes use only `din[0]`, and bits above it have no effect. A read drives the 1-bit status onto every bit of the data output.
- R5: A claim on a flag owned by the other port is refused, and the owner keeps the flag.
- R6: A refused claim stays pending. When the owner releases (write with `din[0]`=1), the flag passes to the waiting port on the same edge.
- R7: If both ports claim the same free flag on the same edge, the left port becomes owner and the right claim becomes pending. The two ports never both read 0 for one flag.
- R8: A write of 1 by a port that does not own the flag cancels that port's pending claim and leaves the current owner unchanged.
- R9: A release with no pending claim from the other side leaves the flag free, so both ports read 1.
- R10: A read sampled at edge k presents the flag status as it stood just before edge k, on the output from edge k onward. The output holds until that port's next read.
- R11: An access changes only the flag selected by its 3-bit address. All other flags keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lt_mem_en | input | 1 | Left memory enable; must be 0 for flag access |
| lt_flag_en | input | 1 | Left flag select; 1 selects the flag bank |
| lt_wr | input | 1 | Left direction: 1 write, 0 read |
| lt_addr | input | AW (3) | Left flag index |
| lt_din | input | DW (8) | Left write data; only bit 0 is used |
| lt_dout | output | DW (8) | Left read status, replicated on all bits |
| rt_mem_en | input | 1 | Right memory enable; must be 0 for flag access |
| rt_flag_en | input | 1 | Right flag select; 1 selects the flag bank |
| rt_wr | input | 1 | Right direction: 1 write, 0 read |
| rt_addr | input | AW (3) | Right flag index |
| rt_din | input | DW (8) | Right write data; only bit 0 is used |
| rt_dout | output | DW (8) | Right read status, replicated on all bits |

## Verification
Every result appears exactly one edge after the access that causes it. A write changes ownership at the edge that samples it. A read loads the status as it stood before that same edge into the output register. The bench drives a step's inputs at the falling edge, lets one rising edge pass, and compares both outputs at the next falling edge. It compares them against a bench-side ownership model that updates at that rising edge, so every check lands in the first cycle a result is due. Directed sequences cover claim, refusal, hand-over, left-priority ties, cancellation and out-of-space accesses. A long pseudo-random sweep on a narrowed address set then forces frequent collisions.

// File: rtl/sem_pkg.sv
// Shared types for the semaphore flag bank.
package sem_pkg;
    // Ownership state of one flag.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/sem_port_decode.sv
// Per-port access decoder.
// Turns one port's strobes into one-hot claim and release vectors and a read strobe.
// Assumes an access is valid only with the flag select high and the memory enable low.
module sem_port_decode #(
    parameter int NFLAGS = 8,
    parameter int AW     = 3
) (
    input  logic              mem_en,
    input  logic              flag_en,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic              wbit,
    output logic [NFLAGS-1:0] claim_vec,
    output logic [NFLAGS-1:0] free_vec,
    output logic              rd_stb
);
    logic acc;
    logic wr_stb;

    // Qualify the access for the flag space.
    always_comb begin
        acc    = flag_en & ~mem_en;
        wr_stb = acc & wr;
        rd_stb = acc & ~wr;
    end

    // One decode slice per flag.
    for (genvar i = 0; i < NFLAGS; i++) begin : g_dec
        assign claim_vec[i] = wr_stb && (addr == AW'(i)) && !wbit;
        assign free_vec[i]  = wr_stb && (addr == AW'(i)) &&  wbit;
    end
endmodule

// File: rtl/sem_flag_cell.sv
// One semaphore flag with an owner and one pending-claim bit per port.
// Left wins a tie on a free flag. A release hands the flag to a waiting port on the same edge.
// A write of 1 from a non-owner cancels that port's pending claim.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_claim,
    input  logic l_free,
    input  logic r_claim,
    input  logic r_free,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);
    owner_e owner_q, owner_d;
    logic   pl_q, pr_q, pl_d, pr_d;
    logic   l_want, r_want;

    // Resolve the next owner and pending bits.
    always_comb begin
        l_want  = l_claim | (pl_q & ~l_free);
        r_want  = r_claim | (pr_q & ~r_free);
        owner_d = owner_q;
        if (owner_q == OWN_LEFT && l_free)  owner_d = OWN_NONE;
        if (owner_q == OWN_RIGHT && r_free) owner_d = OWN_NONE;
        if (owner_d == OWN_NONE) begin
            if (l_want)      owner_d = OWN_LEFT;
            else if (r_want) owner_d = OWN_RIGHT;
        end
        pl_d = l_want && (owner_d != OWN_LEFT);
        pr_d = r_want && (owner_d != OWN_RIGHT);
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
            pl_q    <= 1'b0;
            pr_q    <= 1'b0;
        end else begin
            owner_q <= owner_d;
            pl_q    <= pl_d;
            pr_q    <= pr_d;
        end
    end

    // Expose the state as flat status bits.
    always_comb begin
        own_l  = (owner_q == OWN_LEFT);
        own_r  = (owner_q == OWN_RIGHT);
        pend_l = pl_q;
        pend_r = pr_q;
    end
endmodule

// File: rtl/sem_readout.sv
// Per-port read register.
// On a read it captures the pre-edge status of the addressed flag and drives it onto every data bit.
// Assumes NFLAGS is a power of two that matches AW.
module sem_readout #(
    parameter int NFLAGS = 8,
    parameter int AW     = 3,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [AW-1:0]     addr,
    input  logic [NFLAGS-1:0] mine,
    output logic [DW-1:0]     dout
);
    // Load on read and hold otherwise; reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '1;
        else if (rd_stb) dout <= {DW{~mine[addr]}};
    end
endmodule

// File: rtl/sem_latch_bank.sv
// Top level: a bank of NFLAGS semaphore flags shared by a left port and a right port.
// Both ports are sampled on each rising edge. Writes change ownership at that edge.
// Reads return the pre-edge status, registered.
module sem_latch_bank #(
    parameter int NFLAGS = 8,
    parameter int DW     = 8,
    parameter int AW     = $clog2(NFLAGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lt_mem_en,
    input  logic          lt_flag_en,
    input  logic          lt_wr,
    input  logic [AW-1:0] lt_addr,
    input  logic [DW-1:0] lt_din,
    output logic [DW-1:0] lt_dout,
    input  logic          rt_mem_en,
    input  logic          rt_flag_en,
    input  logic          rt_wr,
    input  logic [AW-1:0] rt_addr,
    input  logic [DW-1:0] rt_din,
    output logic [DW-1:0] rt_dout
);
    logic [NFLAGS-1:0] l_claim, l_free, r_claim, r_free;
    logic [NFLAGS-1:0] own_l, own_r, pend_l, pend_r;
    logic              l_rd, r_rd;
    logic              unused_din_hi;

    // Upper data bits carry no meaning on writes.
    assign unused_din_hi = ^{lt_din[DW-1:1], rt_din[DW-1:1]};

    sem_port_decode #(.NFLAGS(NFLAGS), .AW(AW)) u_dec_l (
        .mem_en(lt_mem_en), .flag_en(lt_flag_en), .wr(lt_wr), .addr(lt_addr),
        .wbit(lt_din[0]), .claim_vec(l_claim), .free_vec(l_free), .rd_stb(l_rd)
    );

    sem_port_decode #(.NFLAGS(NFLAGS), .AW(AW)) u_dec_r (
        .mem_en(rt_mem_en), .flag_en(rt_flag_en), .wr(rt_wr), .addr(rt_addr),
        .wbit(rt_din[0]), .claim_vec(r_claim), .free_vec(r_free), .rd_stb(r_rd)
    );

    // One flag cell per semaphore.
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_claim(l_claim[i]), .l_free(l_free[i]),
            .r_claim(r_claim[i]), .r_free(r_free[i]),
            .own_l(own_l[i]), .own_r(own_r[i]),
            .pend_l(pend_l[i]), .pend_r(pend_r[i])
        );
    end

    sem_readout #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_stb(l_rd), .addr(lt_addr),
        .mine(own_l), .dout(lt_dout)
    );

    sem_readout #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_stb(r_rd), .addr(rt_addr),
        .mine(own_r), .dout(rt_dout)
    );
endmodule

// File: rtl/sem_latch_bank_chk.sv
// Property checker for sem_latch_bank, attached with bind.
module sem_latch_bank_chk #(
    parameter int NFLAGS = 8,
    parameter int DW     = 8,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_mem_en,
    input logic              lt_flag_en,
    input logic              lt_wr,
    input logic [AW-1:0]     lt_addr,
    input logic              lt_wbit,
    input logic [DW-1:0]     lt_dout,
    input logic              rt_mem_en,
    input logic              rt_flag_en,
    input logic              rt_wr,
    input logic [AW-1:0]     rt_addr,
    input logic              rt_wbit,
    input logic [DW-1:0]     rt_dout,
    input logic [NFLAGS-1:0] own_l,
    input logic [NFLAGS-1:0] own_r,
    input logic [NFLAGS-1:0] pend_l,
    input logic [NFLAGS-1:0] pend_r
);
    logic l_acc, r_acc, l_rd, r_rd;
    assign l_acc = lt_flag_en && !lt_mem_en;
    assign r_acc = rt_flag_en && !rt_mem_en;
    assign l_rd  = l_acc && !lt_wr;
    assign r_rd  = r_acc && !rt_wr;

    // R1
    rst_ones_chk: assert property (@(posedge clk)
        !rst_n |=> (lt_dout == '1 && rt_dout == '1));

    // R10
    lt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(lt_dout));

    // R10
    rt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(rt_dout));

    // R4
    repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_dout == '0 || lt_dout == '1) && (rt_dout == '0 || rt_dout == '1));

    // R7
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd && r_rd && lt_addr == rt_addr) |=> !(lt_dout[0] == 1'b0 && rt_dout[0] == 1'b0));

    // R3
    grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && lt_wr && !lt_wbit && !own_l[lt_addr] && !own_r[lt_addr])
        |=> own_l[$past(lt_addr)]);

    // R5
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && lt_wr && !lt_wbit && own_r[lt_addr]
         && !(r_acc && rt_wr && rt_wbit && rt_addr == lt_addr))
        |=> own_r[$past(lt_addr)]);

    // R6
    handoff_r2l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_acc && rt_wr && rt_wbit && own_r[rt_addr] && pend_l[rt_addr]
         && !(l_acc && lt_wr && lt_wbit && lt_addr == rt_addr))
        |=> own_l[$past(rt_addr)]);

    // R6
    handoff_l2r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && lt_wr && lt_wbit && own_l[lt_addr] && pend_r[lt_addr]
         && !(r_acc && rt_wr && rt_wbit && rt_addr == lt_addr))
        |=> own_r[$past(lt_addr)]);
endmodule

bind sem_latch_bank sem_latch_bank_chk #(.NFLAGS(NFLAGS), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lt_mem_en(lt_mem_en), .lt_flag_en(lt_flag_en), .lt_wr(lt_wr), .lt_addr(lt_addr),
    .lt_wbit(lt_din[0]), .lt_dout(lt_dout),
    .rt_mem_en(rt_mem_en), .rt_flag_en(rt_flag_en), .rt_wr(rt_wr), .rt_addr(rt_addr),
    .rt_wbit(rt_din[0]), .rt_dout(rt_dout),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/tb_sem_latch_bank.sv
`timescale 1ns/1ps
module tb_sem_latch_bank;
    localparam int NF = 8;
    localparam int DW = 8;
    localparam int AW = 3;
    // Step operation codes used by the bench
    localparam int OP_IDLE = 0, OP_RD = 1, OP_CLAIM = 2, OP_FREE = 3, OP_MEM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lme = 0, lfe = 0, lwr = 0, rme = 0, rfe = 0, rwr = 0;
    logic [AW-1:0] la = '0, ra = '0;
    logic [DW-1:0] ld = '0, rd = '0;
    logic [DW-1:0] lq, rq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench-side ownership model: 0 free, 1 left, 2 right
    int own [NF];
    bit pl [NF];
    bit pr [NF];
    logic [DW-1:0] exp_l, exp_r;

    always #2.5 clk = ~clk;

    sem_latch_bank #(.NFLAGS(NF), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lt_mem_en(lme), .lt_flag_en(lfe), .lt_wr(lwr), .lt_addr(la), .lt_din(ld), .lt_dout(lq),
        .rt_mem_en(rme), .rt_flag_en(rfe), .rt_wr(rwr), .rt_addr(ra), .rt_din(rd), .rt_dout(rq)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] expv, string side);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: %s dout=%h expected %h", tag, side, act, expv);
        end
    endtask

    task automatic set_port(int op, int a, logic [DW-1:0] hi, output logic me, output logic fe,
                            output logic wr, output logic [AW-1:0] ad, output logic [DW-1:0] d);
        me = (op == OP_MEM);
        fe = (op != OP_IDLE);
        wr = (op == OP_CLAIM || op == OP_FREE || op == OP_MEM);
        ad = AW'(a);
        d  = {hi[DW-1:1], (op == OP_FREE)};
    endtask

    // One cycle: drive, let one edge pass, update model, compare at falling edge.
    task automatic step(int lop, int lad, int rop, int rad, logic [DW-1:0] lhi,
                        logic [DW-1:0] rhi, string tag);
        set_port(lop, lad, lhi, lme, lfe, lwr, la, ld);
        set_port(rop, rad, rhi, rme, rfe, rwr, ra, rd);
        @(posedge clk);
        if (lop == OP_RD) exp_l = {DW{own[lad] != 1}};
        if (rop == OP_RD) exp_r = {DW{own[rad] != 2}};
        for (int f = 0; f < NF; f++) begin
            bit lc, lf, rc, rf, lw, rw;
            int o;
            lc = (lop == OP_CLAIM) && (lad == f);
            lf = (lop == OP_FREE)  && (lad == f);
            rc = (rop == OP_CLAIM) && (rad == f);
            rf = (rop == OP_FREE)  && (rad == f);
            lw = lc | (pl[f] & !lf);
            rw = rc | (pr[f] & !rf);
            o = own[f];
            if (o == 1 && lf) o = 0;
            if (o == 2 && rf) o = 0;
            if (o == 0) begin
                if (lw) o = 1;
                else if (rw) o = 2;
            end
            pl[f] = lw && (o != 1);
            pr[f] = rw && (o != 2);
            own[f] = o;
        end
        @(negedge clk);
        check(tag, lq, exp_l, "left");
        check(tag, rq, exp_r, "right");
    endtask

    // Read one flag from both ports.
    task automatic peek(int a, string tag);
        step(OP_RD, a, OP_RD, a, 8'h00, 8'h00, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        for (int f = 0; f < NF; f++) begin own[f] = 0; pl[f] = 0; pr[f] = 0; end
        exp_l = '1;
        exp_r = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs all ones right after reset
        check("R1", lq, '1, "left");
        check("R1", rq, '1, "right");
        // R1: every flag free from both sides
        for (int f = 0; f < NF; f++) peek(f, "R1");

        // R3: left claims flag 2
        step(OP_CLAIM, 2, OP_IDLE, 0, 8'hA4, 8'h00, "R3");
        peek(2, "R3");
        // R11: neighbours untouched
        peek(1, "R11");
        peek(3, "R11");
        // R5: right claim refused
        step(OP_IDLE, 0, OP_CLAIM, 2, 8'h00, 8'h5A, "R5");
        peek(2, "R5");
        // R6: left release hands flag to right
        step(OP_FREE, 2, OP_IDLE, 0, 8'h00, 8'h00, "R6");
        peek(2, "R6");
        // R9: right release, nobody waiting
        step(OP_IDLE, 0, OP_FREE, 2, 8'h00, 8'hF0, "R9");
        peek(2, "R9");

        // R7: tie on free flag 5, left wins
        step(OP_CLAIM, 5, OP_CLAIM, 5, 8'h00, 8'h00, "R7");
        peek(5, "R7");
        // R10: right reads while left releases; right sees pre-edge value
        step(OP_FREE, 5, OP_RD, 5, 8'h00, 8'h00, "R10");
        step(OP_IDLE, 0, OP_IDLE, 0, 8'h00, 8'h00, "R10");
        peek(5, "R6");
        step(OP_IDLE, 0, OP_FREE, 5, 8'h00, 8'h00, "R9");

        // R8: right pending, then cancels; left release leaves flag free
        step(OP_CLAIM, 1, OP_IDLE, 0, 8'h00, 8'h00, "R8");
        step(OP_IDLE, 0, OP_CLAIM, 1, 8'h00, 8'h00, "R8");
        step(OP_IDLE, 0, OP_FREE, 1, 8'h00, 8'h00, "R8");
        peek(1, "R8");
        step(OP_FREE, 1, OP_IDLE, 0, 8'h00, 8'h00, "R8");
        peek(1, "R8");

        // R2: writes in memory space and with select low have no effect
        step(OP_MEM, 0, OP_MEM, 0, 8'h00, 8'h00, "R2");
        step(OP_IDLE, 0, OP_IDLE, 0, 8'h00, 8'h00, "R2");
        peek(0, "R2");

        // R4: upper data bits ignored; write 0xFE claims, 0x01 releases
        step(OP_IDLE, 0, OP_CLAIM, 7, 8'h00, 8'hFE, "R4");
        peek(7, "R4");
        step(OP_IDLE, 0, OP_FREE, 7, 8'h00, 8'h00, "R4");
        peek(7, "R4");

        // R11: sweep with pseudo-random operations on a narrowed address set
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            int lop, rop, lad, rad;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            lop = int'(lfsr[2:0]) % 5;
            rop = int'(lfsr[5:3]) % 5;
            lad = int'(lfsr[7:6]);
            rad = int'(lfsr[9:8]);
            step(lop, lad, rop, rad, {lfsr[15:9], 1'b0}, {lfsr[12:6], 1'b0}, "R11");
        end
        for (int f = 0; f < NF; f++) peek(f, "R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule